// File: doc/BRIEF.md
# E1 Sa-Bit Data Link Port

This block carries a low-rate serial maintenance link in the spare national bits of an E1 line. These are the Sa4 to Sa8 positions of timeslot 0. They exist only in the non-frame-alignment (NFAS) word, which appears on every second frame. A five-bit select word marks which of the five positions belong to the link. Each enabled position adds 4 kb/s, so the link runs at 4, 8, 12, 16 or 20 kb/s.

A 2.048 MHz bit enable, a mid-bit strobe and a frame-start strobe drive the timebase. It counts the 256 bit times of a frame and tags alternate frames as NFAS.

On the transmit side, the block emits a burst clock pulse at the start of each selected Sa slot. It captures the serial link input at that edge, and the captured bit replaces any other source for that slot. Unselected slots take their value from a default input. On the receive side, the block presents each received bit from a selected slot on a link data output, together with an aligned clock pulse. It leaves that output untouched for all other bits.

Top module: `e1_sa_link`

## Requirements
- R1: While reset is high, and after its release until the first bit enable, every output is 0. The first frame after reset is an alignment (non-NFAS) frame.
- R2: Bit times are counted 0 to 255 from the frame start. Sa4..Sa8 sit at bit times 3..7 of NFAS frames only. Frames alternate between alignment and NFAS. `tx_sa_vld_o` is high for exactly those five bit times of each NFAS frame.
- R3: `txl_clk_o` rises at the bit-enable edge that opens a selected Sa slot and falls at the following mid-bit strobe. It never pulses elsewhere. `sa_sel_i[0]` selects Sa4 (bit time 3) and so on up to `sa_sel_i[4]`, which selects Sa8 (bit time 7).
- R4: In a selected slot, `tx_sa_o` carries the `txl_data_i` value sampled at the edge where `txl_clk_o` rises. This overrides the default input.
- R5: In an unselected Sa slot, `tx_sa_o` carries `tx_dflt_i[k]` (k = 0 for Sa4 .. 4 for Sa8). Outside Sa slots, `tx_sa_o` is 0.
- R6: For a selected slot, `rx_bit_i`, sampled with that bit's enable, appears on `rxl_data_o` after that edge. `rxl_clk_o` is high from that edge until the mid-bit strobe.
- R7: `rxl_data_o` keeps its value through every bit time that is not a selected Sa slot.
- R8: A change of `sa_sel_i` takes effect only from the start of the next NFAS frame. Changes made within a frame do not alter that frame.
- R9: A frame-start strobe forces the next bit time to 0 and flips the frame parity. Without the strobe, the count wraps from 255 to 0 and flips the parity by itself.
- R10: The number of `txl_clk_o` pulses in an NFAS frame equals the number of ones in the active select word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe per 2.048 MHz bit time |
| mid_en | input | 1 | One-cycle strobe at the middle of each bit time |
| frame_start | input | 1 | With bit_en, marks bit time 0 of a frame |
| sa_sel_i | input | 5 | Link select, bit 0 = Sa4 .. bit 4 = Sa8 |
| tx_dflt_i | input | 5 | Default values for unselected Sa slots |
| txl_data_i | input | 1 | Serial transmit link data |
| txl_clk_o | output | 1 | Transmit link burst clock |
| tx_sa_o | output | 1 | Bit to place in the current Sa slot |
| tx_sa_vld_o | output | 1 | High during Sa slots of NFAS frames |
| rx_bit_i | input | 1 | Received line bit for the current bit time |
| rxl_clk_o | output | 1 | Receive link burst clock |
| rxl_data_o | output | 1 | Receive link data |

## Verification
Some properties hold on every cycle, and the in-line assertions check them there. A transmit pulse only occurs inside a valid Sa slot and is gone after the mid-bit strobe. The bit under a rising transmit clock equals the captured link input. The receive data changes only with a rising receive clock. The active select word changes only at the start of an NFAS frame. The directed scenarios cover what needs whole frames to show. These are the slot positions and the frame alternation, the mapping of each select bit to its Sa position, default and override values, the deferral of select changes, realignment by the frame strobe, free-running wrap, and the pulse count per frame.

// File: rtl/e1_sa_pkg.sv
package e1_sa_pkg;
    localparam int FRAME_BITS = 256;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int SA_NUM     = 5;
    localparam int SA_FIRST   = 3;

    typedef logic [BIT_W-1:0]  bitpos_t;
    typedef logic [SA_NUM-1:0] sa_vec_t;

    // position of the bit time about to start, with the select word in force
    typedef struct packed {
        bitpos_t pos;
        logic    nfas;
        sa_vec_t sel;
    } slot_pos_t;

    // one-hot marker of the Sa slot at this position (zero outside slots)
    function automatic sa_vec_t slot_onehot(slot_pos_t p);
        sa_vec_t oh;
        oh = '0;
        for (int k = 0; k < SA_NUM; k++) begin
            if (p.pos == bitpos_t'(SA_FIRST + k)) oh[k] = p.nfas;
        end
        return oh;
    endfunction
endpackage

// File: rtl/e1_sa_timebase.sv
module e1_sa_timebase
    import e1_sa_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_en,
    input  logic      frame_start,
    input  sa_vec_t   sa_sel_i,
    output slot_pos_t nxt_o
);
    localparam bitpos_t LAST = bitpos_t'(FRAME_BITS - 1);

    bitpos_t cnt_q;
    logic    nfas_q;
    sa_vec_t sel_q;
    slot_pos_t nxt;

    always_comb begin
        nxt.pos  = (frame_start || cnt_q == LAST) ? '0 : cnt_q + bitpos_t'(1);
        nxt.nfas = (nxt.pos == '0) ? ~nfas_q : nfas_q;
        nxt.sel  = (nxt.pos == '0 && nxt.nfas) ? sa_sel_i : sel_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= LAST;
            nfas_q <= 1'b1;
            sel_q  <= '0;
        end else if (bit_en) begin
            cnt_q  <= nxt.pos;
            nfas_q <= nxt.nfas;
            sel_q  <= nxt.sel;
        end
    end

    assign nxt_o = nxt;

    a_r8_sel_at_nfas_start: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_q) |-> (cnt_q == '0 && nfas_q));

    a_r9_strobe_realigns: assert property (@(posedge clk) disable iff (rst)
        (bit_en && frame_start) |=> (cnt_q == '0));
endmodule

// File: rtl/e1_sa_tx.sv
module e1_sa_tx
    import e1_sa_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_en,
    input  logic      mid_en,
    input  slot_pos_t nxt_i,
    input  sa_vec_t   tx_dflt_i,
    input  logic      txl_data_i,
    output logic      txl_clk_o,
    output logic      tx_sa_o,
    output logic      tx_sa_vld_o
);
    sa_vec_t oh;
    logic    hit;

    always_comb begin
        oh  = slot_onehot(nxt_i);
        hit = |(oh & nxt_i.sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            txl_clk_o   <= 1'b0;
            tx_sa_o     <= 1'b0;
            tx_sa_vld_o <= 1'b0;
        end else if (bit_en) begin
            txl_clk_o   <= hit;
            tx_sa_vld_o <= |oh;
            tx_sa_o     <= hit ? txl_data_i : |(oh & tx_dflt_i);
        end else if (mid_en) begin
            txl_clk_o   <= 1'b0;
        end
    end

    a_r3_pulse_in_slot: assert property (@(posedge clk) disable iff (rst)
        txl_clk_o |-> tx_sa_vld_o);

    a_r3_low_after_mid: assert property (@(posedge clk) disable iff (rst)
        (mid_en && !bit_en) |=> !txl_clk_o);

    a_r4_override: assert property (@(posedge clk) disable iff (rst)
        $rose(txl_clk_o) |-> (tx_sa_o == $past(txl_data_i)));
endmodule

// File: rtl/e1_sa_rx.sv
module e1_sa_rx
    import e1_sa_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_en,
    input  logic      mid_en,
    input  slot_pos_t nxt_i,
    input  logic      rx_bit_i,
    output logic      rxl_clk_o,
    output logic      rxl_data_o
);
    logic hit;

    always_comb hit = |(slot_onehot(nxt_i) & nxt_i.sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            rxl_clk_o  <= 1'b0;
            rxl_data_o <= 1'b0;
        end else if (bit_en) begin
            rxl_clk_o <= hit;
            if (hit) rxl_data_o <= rx_bit_i;
        end else if (mid_en) begin
            rxl_clk_o <= 1'b0;
        end
    end

    a_r7_data_moves_with_clock: assert property (@(posedge clk) disable iff (rst)
        !$stable(rxl_data_o) |-> $rose(rxl_clk_o));

    a_r6_low_after_mid: assert property (@(posedge clk) disable iff (rst)
        (mid_en && !bit_en) |=> !rxl_clk_o);
endmodule

// File: rtl/e1_sa_link.sv
module e1_sa_link
    import e1_sa_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             mid_en,
    input  logic             frame_start,
    input  logic [SA_NUM-1:0] sa_sel_i,
    input  logic [SA_NUM-1:0] tx_dflt_i,
    input  logic             txl_data_i,
    output logic             txl_clk_o,
    output logic             tx_sa_o,
    output logic             tx_sa_vld_o,
    input  logic             rx_bit_i,
    output logic             rxl_clk_o,
    output logic             rxl_data_o
);
    slot_pos_t nxt;

    e1_sa_timebase u_tb (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .frame_start(frame_start),
        .sa_sel_i   (sa_sel_i),
        .nxt_o      (nxt)
    );

    e1_sa_tx u_tx (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .mid_en     (mid_en),
        .nxt_i      (nxt),
        .tx_dflt_i  (tx_dflt_i),
        .txl_data_i (txl_data_i),
        .txl_clk_o  (txl_clk_o),
        .tx_sa_o    (tx_sa_o),
        .tx_sa_vld_o(tx_sa_vld_o)
    );

    e1_sa_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .mid_en    (mid_en),
        .nxt_i     (nxt),
        .rx_bit_i  (rx_bit_i),
        .rxl_clk_o (rxl_clk_o),
        .rxl_data_o(rxl_data_o)
    );

    a_r5_quiet_outside_slot: assert property (@(posedge clk) disable iff (rst)
        !tx_sa_vld_o |-> (!tx_sa_o && !rxl_clk_o));
endmodule

// File: tb/e1_sa_link_tb_top.sv
module e1_sa_link_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0, mid_en = 1'b0, frame_start = 1'b0;
    logic [4:0] sa_sel_i = '0, tx_dflt_i = '0;
    logic txl_data_i = 1'b0, rx_bit_i = 1'b0;
    logic txl_clk_o, tx_sa_o, tx_sa_vld_o, rxl_clk_o, rxl_data_o;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    e1_sa_link dut_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .mid_en(mid_en),
        .frame_start(frame_start), .sa_sel_i(sa_sel_i), .tx_dflt_i(tx_dflt_i),
        .txl_data_i(txl_data_i), .txl_clk_o(txl_clk_o), .tx_sa_o(tx_sa_o),
        .tx_sa_vld_o(tx_sa_vld_o), .rx_bit_i(rx_bit_i), .rxl_clk_o(rxl_clk_o),
        .rxl_data_o(rxl_data_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // one frame of nbits bit times, four clocks each; checks every Sa slot
    task automatic run_frame(input bit fs, input int nbits, input bit exp_nfas,
                             input logic [4:0] exp_sel, input logic [4:0] txp,
                             input logic [4:0] rxp, input logic [4:0] dflt,
                             input int chg_at, input logic [4:0] chg_val, input string note);
        int pulses = 0;
        bit bad_out = 1'b0, bad_mid = 1'b0;
        tx_dflt_i = dflt;
        for (int b = 0; b < nbits; b++) begin
            bit in_sa = exp_nfas && b >= 3 && b <= 7;
            int k = in_sa ? b - 3 : 0;
            bit selk = in_sa && exp_sel[k];
            logic prev_rxd;
            @(negedge clk);
            if (b == chg_at) sa_sel_i = chg_val;
            prev_rxd    = rxl_data_o;
            bit_en      = 1'b1;
            frame_start = fs && (b == 0);
            txl_data_i  = (b >= 3 && b <= 7) ? txp[b-3] : 1'b1;
            rx_bit_i    = (b >= 3 && b <= 7) ? rxp[b-3] : ~prev_rxd;
            @(negedge clk);
            bit_en = 1'b0; frame_start = 1'b0;
            txl_data_i = ~txl_data_i;
            if (txl_clk_o) pulses++;
            if (in_sa) begin
                chk(tx_sa_vld_o == 1'b1, "R2 slot valid", tx_sa_vld_o, 1);
                chk(txl_clk_o == selk, "R3 tx clock", txl_clk_o, selk);
                chk(tx_sa_o == (selk ? txp[k] : dflt[k]), selk ? "R4 tx override" : "R5 tx default",
                    tx_sa_o, selk ? txp[k] : dflt[k]);
                chk(rxl_clk_o == selk, "R6 rx clock", rxl_clk_o, selk);
                chk(rxl_data_o == (selk ? rxp[k] : prev_rxd), selk ? "R6 rx data" : "R7 rx hold",
                    rxl_data_o, selk ? rxp[k] : prev_rxd);
            end else begin
                if (tx_sa_vld_o || txl_clk_o || tx_sa_o || rxl_clk_o || rxl_data_o != prev_rxd)
                    bad_out = 1'b1;
            end
            @(negedge clk); mid_en = 1'b1;
            @(negedge clk); mid_en = 1'b0;
            if (txl_clk_o || rxl_clk_o) bad_mid = 1'b1;
        end
        chk(!bad_out, {note, " R2 quiet outside Sa slots"}, bad_out, 0);
        chk(!bad_mid, "R3 pulses end at mid strobe", bad_mid, 0);
        if (exp_nfas)
            chk(pulses == $countones(exp_sel), "R10 pulse count", pulses, $countones(exp_sel));
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk({txl_clk_o, tx_sa_o, tx_sa_vld_o, rxl_clk_o, rxl_data_o} == 5'b0, "R1 outputs in reset",
            {txl_clk_o, tx_sa_o, tx_sa_vld_o, rxl_clk_o, rxl_data_o}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk({txl_clk_o, tx_sa_o, tx_sa_vld_o, rxl_clk_o, rxl_data_o} == 5'b0, "R1 outputs after reset",
            {txl_clk_o, tx_sa_o, tx_sa_vld_o, rxl_clk_o, rxl_data_o}, 0);
    endtask

    task automatic test_select_timing();
        sa_sel_i = 5'b10101;
        run_frame(1, 256, 0, 5'b00000, 5'b11111, 5'b11111, 5'b00000, -1, 5'b0, "R1 first frame FAS");
        run_frame(1, 256, 1, 5'b10101, 5'b01011, 5'b10110, 5'b10100, 5, 5'b11111, "R8 mid-frame change");
        run_frame(1, 256, 0, 5'b00000, 5'b00000, 5'b01010, 5'b00000, -1, 5'b0, "R2 FAS");
        run_frame(1, 256, 1, 5'b11111, 5'b10010, 5'b01101, 5'b01101, 200, 5'b00000, "R8 applied");
    endtask

    task automatic test_single_and_none();
        run_frame(1, 256, 0, 5'b00000, 5'b0, 5'b0, 5'b0, -1, 5'b0, "R2 FAS");
        run_frame(1, 256, 1, 5'b00000, 5'b11111, 5'b11111, 5'b01010, 250, 5'b00001, "R5 none selected");
        run_frame(1, 256, 0, 5'b00000, 5'b0, 5'b0, 5'b0, -1, 5'b0, "R2 FAS");
        run_frame(1, 256, 1, 5'b00001, 5'b11110, 5'b00001, 5'b11111, -1, 5'b0, "R3 Sa4 only");
    endtask

    task automatic test_realign_and_wrap();
        run_frame(1, 100, 0, 5'b00000, 5'b0, 5'b0, 5'b0, -1, 5'b0, "R9 short frame");
        run_frame(1, 256, 1, 5'b00001, 5'b00000, 5'b00000, 5'b00000, 10, 5'b10010, "R9 realigned");
        run_frame(0, 256, 0, 5'b00000, 5'b0, 5'b0, 5'b0, -1, 5'b0, "R9 wrap FAS");
        run_frame(0, 256, 1, 5'b10010, 5'b10000, 5'b10010, 5'b01101, -1, 5'b0, "R9 wrap NFAS");
    endtask

    initial begin
        test_reset();
        test_select_timing();
        test_single_and_none();
        test_realign_and_wrap();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule